// File: doc/BRIEF.md
# Iterative In-Place AES-128 Cipher Core

This core encrypts or decrypts one 128-bit block under a 128-bit key. It does the work in place, on a state register and a key register. The host loads both registers through parallel ports while the core is idle. It picks a direction and pulses `start`. It then waits for `done` and reads the result back from the same registers. The round key is advanced inside the key register as the rounds run. Encryption steps the schedule forward from the cipher key. Decryption steps it backward, starting from the tenth round key.

Each round uses one shared byte substitution unit, so it costs 21 cycles: 16 state-byte lookups, 4 key-word lookups and 1 combine cycle. The core then idles until a fixed total latency has elapsed. Because of this, every operation takes exactly the same number of cycles from start to done. When an operation finishes, the key register holds the opposite end of the schedule. A block can therefore be encrypted and then decrypted without reloading the key.

Top module: `aes_iter_core`

## Requirements
- R1: With `dir`=0, the state read-back after done equals the AES-128 encryption of the loaded block under the loaded key. Bytes are ordered so that byte 0 is bits [127:120], and columns are built from bytes 4c..4c+3.
- R2: With `dir`=1 and the tenth round key loaded as the key, the state read-back after done equals the AES-128 decryption of the loaded block.
- R3: After an encryption, the key read-back equals the tenth round key of the expanded key schedule.
- R4: After a decryption, the key read-back equals the original cipher key.
- R5: `done` is high in the cycle that follows the LATENCY-th rising edge after the edge that sampled `start` (LATENCY = 375 by default).
- R6: `done` is a single-cycle pulse. `busy` is high from the edge that samples `start` until the edge that raises `done`, and low together with `done`.
- R7: While `busy` is high, `load_state` and `load_key` have no effect on the result.
- R8: While `busy` is high, `start` is ignored and neither restarts nor lengthens the operation.
- R9: After reset, `busy` and `done` are low and both read-back ports are zero.
- R10: While idle, `load_state`/`load_key` replace the matching register at the next edge, and the value appears on the read-back port. If `start` is sampled in the same cycle, it takes priority and the loads are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| dir | input | 1 | 0 = encrypt, 1 = decrypt (sampled with start) |
| load_state | input | 1 | Write `state_i` into the state register when idle |
| load_key | input | 1 | Write `key_i` into the key register when idle |
| state_i | input | 128 | Block to load |
| key_i | input | 128 | Key to load (cipher key or tenth round key) |
| state_o | output | 128 | State register read-back |
| key_o | output | 128 | Key register read-back |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the core with its default LATENCY of 375. With that value the full schedule and the idle padding are both exercised on every operation. A sweep of generated key and block pairs runs each pair through an encryption, then a decryption fed by the returned key, against an arithmetic AES model in the bench. That model builds its substitution table by searching for field inverses. Known-answer values pin down the byte order. One disturbed run injects loads and a second start mid-operation to show that the result and the latency are unaffected.

// File: rtl/aes_iter_pkg.sv
package aes_iter_pkg;

    localparam int NB_BYTES  = 16;
    localparam int NR_ROUNDS = 10;

    typedef enum logic {
        DIR_ENC = 1'b0,
        DIR_DEC = 1'b1
    } aes_dir_e;

    function automatic logic [7:0] xt(input logic [7:0] b);
        return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] xt_inv(input logic [7:0] b);
        return b[0] ? (((b ^ 8'h1b) >> 1) | 8'h80) : (b >> 1);
    endfunction

    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] p;
        acc = 8'h00;
        p   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ p;
            p = xt(p);
        end
        return acc;
    endfunction

    // Multiplicative inverse as x^254 (0 maps to 0).
    function automatic logic [7:0] gf_inv(input logic [7:0] x);
        logic [7:0] p;
        logic [7:0] r;
        p = gmul(x, x);
        r = p;
        for (int k = 2; k < 8; k++) begin
            p = gmul(p, p);
            r = gmul(r, p);
        end
        return r;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
        return (b << n) | (b >> (8 - n));
    endfunction

    function automatic logic [7:0] sub_byte(input logic [7:0] x, input logic inv);
        logic [7:0] b;
        if (!inv) begin
            b = gf_inv(x);
            return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
        end
        b = rotl8(x, 1) ^ rotl8(x, 3) ^ rotl8(x, 6) ^ 8'h05;
        return gf_inv(b);
    endfunction

    function automatic logic [7:0] byte_of(input logic [127:0] s, input int i);
        return s[(15 - i) * 8 +: 8];
    endfunction

    function automatic logic [127:0] shift_rows(input logic [127:0] s, input logic inv);
        logic [127:0] o;
        int src;
        o = '0;
        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 4; r++) begin
                src = inv ? (r + 4 * ((c - r + 4) % 4)) : (r + 4 * ((c + r) % 4));
                o[(15 - (r + 4 * c)) * 8 +: 8] = byte_of(s, src);
            end
        end
        return o;
    endfunction

    function automatic logic [127:0] mix_cols(input logic [127:0] s, input logic inv);
        logic [127:0] o;
        logic [7:0] a0, a1, a2, a3;
        o = '0;
        for (int c = 0; c < 4; c++) begin
            a0 = byte_of(s, 4 * c);
            a1 = byte_of(s, 4 * c + 1);
            a2 = byte_of(s, 4 * c + 2);
            a3 = byte_of(s, 4 * c + 3);
            if (!inv) begin
                o[(15 - 4 * c) * 8 +: 8]       = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
                o[(15 - (4 * c + 1)) * 8 +: 8] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
                o[(15 - (4 * c + 2)) * 8 +: 8] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
                o[(15 - (4 * c + 3)) * 8 +: 8] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
            end else begin
                o[(15 - 4 * c) * 8 +: 8]       = gmul(a0, 8'h0e) ^ gmul(a1, 8'h0b) ^ gmul(a2, 8'h0d) ^ gmul(a3, 8'h09);
                o[(15 - (4 * c + 1)) * 8 +: 8] = gmul(a0, 8'h09) ^ gmul(a1, 8'h0e) ^ gmul(a2, 8'h0b) ^ gmul(a3, 8'h0d);
                o[(15 - (4 * c + 2)) * 8 +: 8] = gmul(a0, 8'h0d) ^ gmul(a1, 8'h09) ^ gmul(a2, 8'h0e) ^ gmul(a3, 8'h0b);
                o[(15 - (4 * c + 3)) * 8 +: 8] = gmul(a0, 8'h0b) ^ gmul(a1, 8'h0d) ^ gmul(a2, 8'h09) ^ gmul(a3, 8'h0e);
            end
        end
        return o;
    endfunction

endpackage

// File: rtl/aes_sbox_unit.sv
module aes_sbox_unit
    import aes_iter_pkg::*;
(
    input  logic [7:0] din,
    input  logic       inv,
    output logic [7:0] dout
);
    always_comb dout = sub_byte(din, inv);
endmodule

// File: rtl/aes_key_step.sv
module aes_key_step
    import aes_iter_pkg::*;
(
    input  logic [127:0] key_i,
    input  logic [31:0]  subw_i,
    input  logic [7:0]   rcon_i,
    input  aes_dir_e     dir_i,
    output logic [31:0]  sbox_src_o,
    output logic [127:0] key_o
);
    logic [31:0] w0, w1, w2, w3, src, rcw, n0, n1, n2, n3;

    always_comb begin
        w0  = key_i[127:96];
        w1  = key_i[95:64];
        w2  = key_i[63:32];
        w3  = key_i[31:0];
        rcw = {rcon_i, 24'h0};
        // Backward: the earlier word 3 is w3^w2, and it feeds the substitution.
        src = (dir_i == DIR_DEC) ? (w3 ^ w2) : w3;
        sbox_src_o = {src[23:0], src[31:24]};
        if (dir_i == DIR_ENC) begin
            n0 = w0 ^ subw_i ^ rcw;
            n1 = w1 ^ n0;
            n2 = w2 ^ n1;
            n3 = w3 ^ n2;
        end else begin
            n3 = w3 ^ w2;
            n2 = w2 ^ w1;
            n1 = w1 ^ w0;
            n0 = w0 ^ subw_i ^ rcw;
        end
        key_o = {n0, n1, n2, n3};
    end
endmodule

// File: rtl/aes_round_finish.sv
module aes_round_finish
    import aes_iter_pkg::*;
(
    input  logic [127:0] sub_i,
    input  logic [127:0] rkey_i,
    input  aes_dir_e     dir_i,
    input  logic         last_i,
    output logic [127:0] state_o
);
    logic [127:0] sh, ak;

    always_comb begin
        sh = shift_rows(sub_i, dir_i == DIR_DEC);
        if (dir_i == DIR_ENC) begin
            ak      = last_i ? sh : mix_cols(sh, 1'b0);
            state_o = ak ^ rkey_i;
        end else begin
            ak      = sh ^ rkey_i;
            state_o = last_i ? ak : mix_cols(ak, 1'b1);
        end
    end
endmodule

// File: rtl/aes_iter_core.sv
module aes_iter_core
    import aes_iter_pkg::*;
#(
    parameter int LATENCY = 375
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         dir,
    input  logic         load_state,
    input  logic         load_key,
    input  logic [127:0] state_i,
    input  logic [127:0] key_i,
    output logic [127:0] state_o,
    output logic [127:0] key_o,
    output logic         busy,
    output logic         done
);
    localparam int ROUND_CYC = NB_BYTES + 4 + 1;
    localparam int CNT_W     = $clog2(LATENCY + 1);
    localparam int PH_W      = $clog2(ROUND_CYC);
    localparam int RND_W     = $clog2(NR_ROUNDS + 2);
    localparam logic [PH_W-1:0]  PH_KEY0 = PH_W'(NB_BYTES);
    localparam logic [PH_W-1:0]  PH_FIN  = PH_W'(NB_BYTES + 4);
    localparam logic [RND_W-1:0] RND_MAX = RND_W'(NR_ROUNDS);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(LATENCY - 1);

    logic [127:0]     state_q, key_q, key_nx, fin_state;
    logic [31:0]      kw_q, ksrc;
    logic [7:0]       rcon_q, sb_in, sb_out;
    logic [CNT_W-1:0] cnt_q;
    logic [PH_W-1:0]  phase_q;
    logic [RND_W-1:0] rnd_q;
    logic             busy_q, done_q, in_round, sb_inv;
    aes_dir_e         dir_q;
    int               sidx, kidx;

    always_comb begin
        sidx     = int'(phase_q);
        kidx     = int'(phase_q) - NB_BYTES;
        in_round = (rnd_q != '0) && (rnd_q <= RND_MAX);
        if (phase_q < PH_KEY0) begin
            sb_in  = state_q[(15 - sidx) * 8 +: 8];
            sb_inv = (dir_q == DIR_DEC);
        end else begin
            sb_in  = ksrc[(3 - (kidx & 3)) * 8 +: 8];
            sb_inv = 1'b0;
        end
    end

    aes_sbox_unit u_sbox (.din(sb_in), .inv(sb_inv), .dout(sb_out));

    aes_key_step u_kstep (
        .key_i(key_q), .subw_i(kw_q), .rcon_i(rcon_q), .dir_i(dir_q),
        .sbox_src_o(ksrc), .key_o(key_nx)
    );

    aes_round_finish u_fin (
        .sub_i(state_q), .rkey_i(key_nx), .dir_i(dir_q),
        .last_i(rnd_q == RND_MAX), .state_o(fin_state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
            key_q   <= '0;
            kw_q    <= '0;
            rcon_q  <= '0;
            cnt_q   <= '0;
            phase_q <= '0;
            rnd_q   <= '0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            dir_q   <= DIR_ENC;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q  <= 1'b1;
                    cnt_q   <= '0;
                    phase_q <= '0;
                    rnd_q   <= '0;
                    dir_q   <= aes_dir_e'(dir);
                    rcon_q  <= dir ? 8'h36 : 8'h01;
                end else begin
                    if (load_state) state_q <= state_i;
                    if (load_key)   key_q   <= key_i;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CNT_END) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
                if (cnt_q == '0) begin
                    state_q <= state_q ^ key_q;
                    rnd_q   <= RND_W'(1);
                    phase_q <= '0;
                end else if (in_round) begin
                    if (phase_q < PH_KEY0) begin
                        state_q[(15 - sidx) * 8 +: 8] <= sb_out;
                        phase_q <= phase_q + 1'b1;
                    end else if (phase_q < PH_FIN) begin
                        kw_q[(3 - (kidx & 3)) * 8 +: 8] <= sb_out;
                        phase_q <= phase_q + 1'b1;
                    end else begin
                        state_q <= fin_state;
                        key_q   <= key_nx;
                        rcon_q  <= (dir_q == DIR_DEC) ? xt_inv(rcon_q) : xt(rcon_q);
                        phase_q <= '0;
                        rnd_q   <= rnd_q + 1'b1;
                    end
                end
            end
        end
    end

    assign state_o = state_q;
    assign key_o   = key_q;
    assign busy    = busy_q;
    assign done    = done_q;

    // R6: completion is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst) done_q |=> !done_q);
    // R6: busy only falls together with done rising
    p_busy_fall_done_r6: assert property (@(posedge clk) disable iff (rst) $fell(busy_q) |-> done_q);
    // R5: the cycle counter never passes the latency bound
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst) busy_q |-> (cnt_q <= CNT_END));
    // R5: all rounds finish before the counter expires
    p_rounds_done_r5: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cnt_q == CNT_END) |-> (rnd_q == RND_MAX + 1'b1));
    // R10: idle state register only changes through a load
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && !load_state) |=> $stable(state_q));
endmodule

// File: tb/aes_iter_core_tb.sv
`timescale 1ns/1ps
module aes_iter_core_tb;
    localparam int LAT = 375;

    logic         clk = 1'b0;
    logic         rst, start, dir, load_state, load_key;
    logic [127:0] state_i, key_i, state_o, key_o;
    logic         busy, done;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] sb [256];

    always #2.5 clk = ~clk;

    aes_iter_core #(.LATENCY(LAT)) u_dut (
        .clk(clk), .rst(rst), .start(start), .dir(dir),
        .load_state(load_state), .load_key(load_key),
        .state_i(state_i), .key_i(key_i),
        .state_o(state_o), .key_o(key_o), .busy(busy), .done(done)
    );

    function automatic logic [7:0] m2(input logic [7:0] b);
        return b[7] ? ((b << 1) ^ 8'h1b) : (b << 1);
    endfunction

    function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 0;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= x;
            x = m2(x);
        end
        return r;
    endfunction

    // Reference encryption; also returns the tenth round key.
    function automatic logic [127:0] ref_enc(input logic [127:0] p, input logic [127:0] k,
                                             output logic [127:0] lastk);
        logic [7:0] s[16], t[16], w[16], a0, a1, a2, a3, rc, g0, g1, g2, g3;
        logic [127:0] o;
        rc = 8'h01;
        for (int i = 0; i < 16; i++) begin
            w[i] = k[127 - 8 * i -: 8];
            s[i] = p[127 - 8 * i -: 8] ^ w[i];
        end
        for (int r = 1; r <= 10; r++) begin
            for (int i = 0; i < 16; i++) t[i] = sb[s[i]];
            for (int c = 0; c < 4; c++)
                for (int q = 0; q < 4; q++) s[q + 4 * c] = t[q + 4 * ((c + q) % 4)];
            if (r < 10) begin
                for (int c = 0; c < 4; c++) begin
                    a0 = s[4*c]; a1 = s[4*c+1]; a2 = s[4*c+2]; a3 = s[4*c+3];
                    s[4*c]   = m2(a0) ^ m2(a1) ^ a1 ^ a2 ^ a3;
                    s[4*c+1] = a0 ^ m2(a1) ^ m2(a2) ^ a2 ^ a3;
                    s[4*c+2] = a0 ^ a1 ^ m2(a2) ^ m2(a3) ^ a3;
                    s[4*c+3] = m2(a0) ^ a0 ^ a1 ^ a2 ^ m2(a3);
                end
            end
            g0 = sb[w[13]]; g1 = sb[w[14]]; g2 = sb[w[15]]; g3 = sb[w[12]];
            w[0] ^= g0 ^ rc; w[1] ^= g1; w[2] ^= g2; w[3] ^= g3;
            for (int j = 4; j < 16; j++) w[j] ^= w[j - 4];
            rc = m2(rc);
            for (int i = 0; i < 16; i++) s[i] ^= w[i];
        end
        for (int i = 0; i < 16; i++) begin
            o[127 - 8 * i -: 8]     = s[i];
            lastk[127 - 8 * i -: 8] = w[i];
        end
        return o;
    endfunction

    task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic load(input logic [127:0] s, input logic [127:0] k);
        @(negedge clk);
        state_i = s; key_i = k; load_state = 1'b1; load_key = 1'b1;
        @(negedge clk);
        load_state = 1'b0; load_key = 1'b0;
    endtask

    // Runs one operation; optionally disturbs it mid-flight with loads and a second start.
    task automatic run_op(input logic d, input logic disturb, output int lat, output logic busy_ok,
                          output logic pulse_ok);
        @(negedge clk);
        dir = d; start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        lat = 0; busy_ok = 1'b1;
        while (lat < 2 * LAT) begin
            @(posedge clk);
            #1;
            lat++;
            if (disturb && lat == 50) begin
                state_i = '1; key_i = '1; load_state = 1'b1; load_key = 1'b1;
                start = 1'b1; dir = ~d;
            end
            if (disturb && lat == 51) begin
                load_state = 1'b0; load_key = 1'b0; start = 1'b0;
            end
            if (done) break;
            if (!busy) busy_ok = 1'b0;
        end
        if (busy) busy_ok = 1'b0;
        @(posedge clk);
        #1 pulse_ok = !done && !busy;
    endtask

    task automatic roundtrip(input logic [127:0] p, input logic [127:0] k, input logic disturb);
        logic [127:0] ct, lk;
        int lat;
        logic bok, pok;
        ct = ref_enc(p, k, lk);
        load(p, k);
        run_op(1'b0, disturb, lat, bok, pok);
        chk(disturb ? "R1/R7/R8 enc disturbed" : "R1 enc", state_o, ct);
        chk("R3 key after enc", key_o, lk);
        chk("R5 enc latency", 128'(lat), 128'(LAT));
        chk("R6 busy/done enc", {127'b0, bok & pok}, 128'd1);
        load(ct, lk);
        run_op(1'b1, disturb, lat, bok, pok);
        chk(disturb ? "R2/R7/R8 dec disturbed" : "R2 dec", state_o, p);
        chk("R4 key after dec", key_o, k);
        chk("R5 dec latency", 128'(lat), 128'(LAT));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] kk, pp, lk, ct;
        logic [7:0] inv, b;
        // Substitution table from a search for field inverses.
        for (int x = 0; x < 256; x++) begin
            inv = 8'h00;
            for (int y = 1; y < 256; y++) if (fmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            b = inv;
            sb[x] = b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]} ^ {b[3:0], b[7:4]} ^ 8'h63;
        end
        rst = 1'b1; start = 1'b0; dir = 1'b0; load_state = 1'b0; load_key = 1'b0;
        state_i = '0; key_i = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        chk("R9 reset state", state_o, '0);
        chk("R9 reset key", key_o, '0);
        chk("R9 reset busy/done", {126'b0, busy, done}, '0);

        // Known answer values pin the byte order (R1, R3).
        kk = 128'h000102030405060708090a0b0c0d0e0f;
        pp = 128'h00112233445566778899aabbccddeeff;
        ct = ref_enc(pp, kk, lk);
        chk("R1 model ct", ct, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
        chk("R3 model lastkey", lk, 128'h13111d7fe3944a17f307a78b4d2b30c5);
        load(pp, kk);
        chk("R10 load state", state_o, pp);
        chk("R10 load key", key_o, kk);
        // R10: start wins over simultaneous loads
        @(negedge clk);
        state_i = '1; load_state = 1'b1; start = 1'b1; dir = 1'b0;
        @(posedge clk);
        #1 start = 1'b0; load_state = 1'b0;
        while (!done) begin @(posedge clk); #1; end
        chk("R10 start priority / R1 known answer", state_o, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);

        roundtrip(pp, kk, 1'b0);
        for (int n = 0; n < 14; n++) begin
            kk = {32'(n) * 32'h9e3779b9, 32'(n + 7) * 32'h85ebca6b, ~(32'(n) * 32'hc2b2ae35), 32'(n) ^ 32'h27d4eb2f};
            pp = {kk[63:0] ^ 64'h0123456789abcdef, kk[127:64] * 64'(n + 3)};
            if (n == 12) begin kk = '0; pp = '0; end
            if (n == 13) begin kk = '1; pp = '1; end
            roundtrip(pp, kk, 1'b0);
        end
        roundtrip(128'hfedcba98765432100123456789abcdef, 128'h2b7e151628aed2a6abf7158809cf4f3c, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule